// File: doc/BRIEF.md
# Multi-Window Glitch Scheduler

This block turns one trigger event into a train of fault-injection enable windows. A small table holds, for each window, a delay in clock cycles and a length in clock cycles. A host loads the table and the number of windows to play while the block is idle. A rising edge on the trigger input then starts the sequence. For each entry in turn, the block waits out the entry's delay, holds the glitch-enable output high for the entry's length, and moves on to the next entry. After the last programmed entry it drops busy and pulses done.

Each delay is counted from the end of the previous window, or from the trigger for the first entry. The pulse shaping that follows the enable, meaning width and phase within a cycle, is common to all windows and sits outside this block. Only the delay and the length change from one entry to the next.

The block uses a single clock with a synchronous active-high reset. The table is a simple dual-port memory with one write port and one registered read port, so it maps onto block RAM.

Top module: `mgs_top`

## Requirements
- R1: After reset, `glitch_en`, `busy` and `done` are low and the programmed window count is 0.
- R2: A sequence starts only on a rising edge of `trig_in`: the trigger must be sampled low on one clock edge and high on the next. `busy` goes high on the edge where the trigger is first sampled high. Holding the trigger high does not start another sequence.
- R3: Let t0 be the edge where the trigger is first sampled high, and let O0 be entry 0's delay. `glitch_en` for entry 0 first goes high on edge t0+2+O0.
- R4: For an entry with length R > 0, `glitch_en` stays high for exactly R consecutive cycles.
- R5: Each entry k > 0 ends its delay relative to the edge where entry k−1's window ended. With delay Ok, its window starts 2+Ok edges after that edge.
- R6: An entry with length 0 drives no `glitch_en` cycles. Its window is treated as ending on the edge where it would have started.
- R7: Entries play in index order, from 0 up to count−1. The count is written through `cnt_we`/`cnt_val`. A value above MAX_ENTRIES is stored as MAX_ENTRIES.
- R8: While the stored count is 0, a trigger edge is ignored and `busy` stays low.
- R9: Trigger edges that arrive while `busy` is high have no effect on the running sequence or on what follows it.
- R10: Table writes (`tbl_we`) and count writes (`cnt_we`) made while `busy` is high are discarded.
- R11: `done` is high for exactly one cycle, on the edge where the last entry's window ends. `busy` falls on that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_in | input | 1 | Trigger; a rising edge starts a sequence |
| tbl_we | input | 1 | Table entry write strobe |
| tbl_addr | input | IDX_W | Entry index to write |
| tbl_ofs | input | OFS_W | Delay in cycles for that entry |
| tbl_rep | input | REP_W | Window length in cycles for that entry |
| cnt_we | input | 1 | Window count write strobe |
| cnt_val | input | CNT_W | Number of entries to play |
| glitch_en | output | 1 | Registered glitch enable |
| busy | output | 1 | High while a sequence runs |
| done | output | 1 | One-cycle pulse at sequence end |

## Verification
The bench builds the block with MAX_ENTRIES=4, OFS_W=3 and REP_W=3.

With these values, every single-entry pair of delay and length (8 × 8) can be played. This covers the zero-delay and zero-length corners in every combination.

Four entries are enough to exercise:
- multi-entry chaining;
- count clamping, using a written value of 7;
- trigger and write interference during a run;
- a shorter count over a fuller table.

All of these runs stay short enough to check every cycle against an arithmetic schedule.

// File: rtl/mgs_pkg.sv
package mgs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LOAD   = 2'd1,
    ST_WAIT   = 2'd2,
    ST_GLITCH = 2'd3
  } seq_state_t;
endpackage

// File: rtl/mgs_edge.sv
module mgs_edge (
  input  logic clk,
  input  logic rst,
  input  logic sig_in,
  output logic rise
);
  logic sig_q;

  // Reset to 1 so that a level already high at reset release is not taken as an edge.
  always_ff @(posedge clk) begin
    if (rst) sig_q <= 1'b1;
    else     sig_q <= sig_in;
  end

  assign rise = sig_in & ~sig_q;
endmodule

// File: rtl/mgs_table.sv
module mgs_table #(
  parameter int DEPTH = 32,
  parameter int AW    = 5,
  parameter int DW    = 46
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Registered read port, so the table can be inferred as block RAM.
  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/mgs_ctrl.sv
module mgs_ctrl
  import mgs_pkg::*;
#(
  parameter int IDX_W = 5,
  parameter int CNT_W = 6,
  parameter int OFS_W = 32,
  parameter int REP_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_req,
  input  logic [CNT_W-1:0] n_entries,
  input  logic [OFS_W-1:0] rd_ofs,
  input  logic [REP_W-1:0] rd_rep,
  output logic [IDX_W-1:0] rd_idx,
  output logic             idle,
  output logic             glitch_en,
  output logic             busy,
  output logic             done
);
  seq_state_t       state, st_n;
  logic [IDX_W-1:0] idx, idx_n;
  logic [OFS_W-1:0] ofs_cnt, ofs_n;
  logic [REP_W-1:0] rep_cnt, rep_n;
  logic             done_n;
  logic             entry_end;
  logic             is_last;

  assign is_last = (CNT_W'(idx) + CNT_W'(1)) == n_entries;

  always_comb begin
    st_n      = state;
    idx_n     = idx;
    ofs_n     = ofs_cnt;
    rep_n     = rep_cnt;
    done_n    = 1'b0;
    entry_end = 1'b0;
    unique case (state)
      ST_IDLE: begin
        idx_n = '0;
        if (start_req && (n_entries != '0)) st_n = ST_LOAD;
      end
      ST_LOAD: begin
        ofs_n = rd_ofs;
        rep_n = rd_rep;
        st_n  = ST_WAIT;
      end
      ST_WAIT: begin
        if (ofs_cnt == '0) begin
          if (rep_cnt != '0) st_n = ST_GLITCH;
          else               entry_end = 1'b1;
        end else begin
          ofs_n = ofs_cnt - OFS_W'(1);
        end
      end
      ST_GLITCH: begin
        if (rep_cnt == REP_W'(1)) entry_end = 1'b1;
        else                      rep_n = rep_cnt - REP_W'(1);
      end
      default: st_n = ST_IDLE;
    endcase
    if (entry_end) begin
      if (is_last) begin
        st_n   = ST_IDLE;
        idx_n  = '0;
        done_n = 1'b1;
      end else begin
        st_n  = ST_LOAD;
        idx_n = idx + IDX_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      idx       <= '0;
      ofs_cnt   <= '0;
      rep_cnt   <= '0;
      glitch_en <= 1'b0;
      busy      <= 1'b0;
      done      <= 1'b0;
    end else begin
      state     <= st_n;
      idx       <= idx_n;
      ofs_cnt   <= ofs_n;
      rep_cnt   <= rep_n;
      glitch_en <= (st_n == ST_GLITCH);
      busy      <= (st_n != ST_IDLE);
      done      <= done_n;
    end
  end

  // The read address follows the next index, so the LOAD cycle sees fresh data.
  assign rd_idx = idx_n;
  assign idle   = (state == ST_IDLE);
endmodule

// File: rtl/mgs_top.sv
module mgs_top #(
  parameter int MAX_ENTRIES = 32,
  parameter int OFS_W       = 32,
  parameter int REP_W       = 14,
  localparam int IDX_W      = (MAX_ENTRIES > 1) ? $clog2(MAX_ENTRIES) : 1,
  localparam int CNT_W      = $clog2(MAX_ENTRIES + 1),
  localparam int ENT_W      = OFS_W + REP_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             trig_in,
  input  logic             tbl_we,
  input  logic [IDX_W-1:0] tbl_addr,
  input  logic [OFS_W-1:0] tbl_ofs,
  input  logic [REP_W-1:0] tbl_rep,
  input  logic             cnt_we,
  input  logic [CNT_W-1:0] cnt_val,
  output logic             glitch_en,
  output logic             busy,
  output logic             done
);
  logic             trig_rise;
  logic             idle;
  logic [IDX_W-1:0] rd_idx;
  logic [ENT_W-1:0] rd_word;
  logic [CNT_W-1:0] cnt_q;

  mgs_edge u_edge (
    .clk    (clk),
    .rst    (rst),
    .sig_in (trig_in),
    .rise   (trig_rise)
  );

  mgs_table #(
    .DEPTH (MAX_ENTRIES),
    .AW    (IDX_W),
    .DW    (ENT_W)
  ) u_table (
    .clk   (clk),
    .we    (tbl_we & idle),
    .waddr (tbl_addr),
    .wdata ({tbl_ofs, tbl_rep}),
    .raddr (rd_idx),
    .rdata (rd_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (cnt_we && idle) begin
      if (cnt_val > CNT_W'(MAX_ENTRIES)) cnt_q <= CNT_W'(MAX_ENTRIES);
      else                               cnt_q <= cnt_val;
    end
  end

  mgs_ctrl #(
    .IDX_W (IDX_W),
    .CNT_W (CNT_W),
    .OFS_W (OFS_W),
    .REP_W (REP_W)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start_req (trig_rise),
    .n_entries (cnt_q),
    .rd_ofs    (rd_word[ENT_W-1:REP_W]),
    .rd_rep    (rd_word[REP_W-1:0]),
    .rd_idx    (rd_idx),
    .idle      (idle),
    .glitch_en (glitch_en),
    .busy      (busy),
    .done      (done)
  );
endmodule

// File: rtl/mgs_checker.sv
module mgs_checker #(
  parameter int CNT_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             trig_in,
  input logic             cnt_we,
  input logic [CNT_W-1:0] cnt_q,
  input logic             glitch_en,
  input logic             busy,
  input logic             done
);
  // R4: enable windows only occur inside a running sequence
  assert_glitch_in_run_R4: assert property (@(posedge clk) disable iff (rst)
    glitch_en |-> busy);

  // R11: done lasts one cycle
  assert_done_single_R11: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R11: busy falls exactly when done is raised
  assert_end_marks_done_R11: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  // R2: a sequence only begins after a sampled low-then-high trigger
  assert_start_on_edge_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> ($past(trig_in) && !$past(trig_in, 2)));

  // R8: a zero count keeps the block idle
  assert_zero_count_idle_R8: assert property (@(posedge clk) disable iff (rst)
    (!busy && cnt_q == '0) |=> !busy);

  // R10: count writes during a run leave the stored count unchanged
  assert_cnt_locked_R10: assert property (@(posedge clk) disable iff (rst)
    (busy && cnt_we) |=> $stable(cnt_q));
endmodule

bind mgs_top mgs_checker #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .trig_in   (trig_in),
  .cnt_we    (cnt_we),
  .cnt_q     (cnt_q),
  .glitch_en (glitch_en),
  .busy      (busy),
  .done      (done)
);

// File: tb/sim_mgs_top.sv
`timescale 1ns/1ps
module sim_mgs_top;
  localparam int MAXE  = 4;
  localparam int OW    = 3;
  localparam int RW    = 3;
  localparam int IW    = 2;
  localparam int CW    = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          trig_in = 1'b0;
  logic          tbl_we = 1'b0;
  logic [IW-1:0] tbl_addr = '0;
  logic [OW-1:0] tbl_ofs = '0;
  logic [RW-1:0] tbl_rep = '0;
  logic          cnt_we = 1'b0;
  logic [CW-1:0] cnt_val = '0;
  logic          glitch_en, busy, done;

  int checks = 0;
  int fails  = 0;
  int m_ofs [MAXE];
  int m_rep [MAXE];
  int m_cnt = 0;

  always #4 clk = ~clk;

  mgs_top #(.MAX_ENTRIES(MAXE), .OFS_W(OW), .REP_W(RW)) u0 (
    .clk(clk), .rst(rst), .trig_in(trig_in), .tbl_we(tbl_we),
    .tbl_addr(tbl_addr), .tbl_ofs(tbl_ofs), .tbl_rep(tbl_rep),
    .cnt_we(cnt_we), .cnt_val(cnt_val),
    .glitch_en(glitch_en), .busy(busy), .done(done)
  );

  task automatic chk(input string tag, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s got=%0d exp=%0d", tag, what, got, exp);
    end
  endtask

  task automatic wr_entry(input int i, input int o, input int r);
    @(negedge clk);
    tbl_we = 1'b1; tbl_addr = IW'(i); tbl_ofs = OW'(o); tbl_rep = RW'(r);
    @(negedge clk);
    tbl_we = 1'b0;
    m_ofs[i] = o; m_rep[i] = r;
  endtask

  task automatic wr_count(input int c);
    @(negedge clk);
    cnt_we = 1'b1; cnt_val = CW'(c);
    @(negedge clk);
    cnt_we = 1'b0;
    m_cnt = (c > MAXE) ? MAXE : c;
  endtask

  // Plays one sequence and compares every cycle with the arithmetic schedule.
  task automatic run(input string tag, input bit interfere, input bit hold);
    int st [MAXE];
    int dend;
    int acc;
    dend = -1;
    acc = 0;
    for (int k = 0; k < m_cnt; k++) begin
      st[k] = acc + 2 + m_ofs[k];
      acc = st[k] + m_rep[k];
      dend = acc;
    end
    @(negedge clk);
    trig_in = 1'b1;
    for (int n = 0; n <= ((dend < 0) ? 6 : dend + 2); n++) begin
      bit eg;
      @(posedge clk);
      @(negedge clk);
      eg = 1'b0;
      for (int k = 0; k < m_cnt; k++)
        if (n >= st[k] && n < st[k] + m_rep[k]) eg = 1'b1;
      chk({tag, " R3 R4 R5 R6"}, $sformatf("glitch_en n=%0d", n), int'(glitch_en), int'(eg));
      chk({tag, " R2"}, $sformatf("busy n=%0d", n), int'(busy), int'(n < dend));
      chk({tag, " R11"}, $sformatf("done n=%0d", n), int'(done), int'(n == dend));
      if (!hold) trig_in = 1'b0;
      if (interfere && n == 1) trig_in = 1'b0;
      if (interfere && n == 2) begin
        trig_in = 1'b1; tbl_we = 1'b1; tbl_addr = '0; tbl_ofs = '1; tbl_rep = '1;
        cnt_we = 1'b1; cnt_val = CW'(1);
      end
      if (interfere && n == 3) begin
        trig_in = 1'b0; tbl_we = 1'b0; cnt_we = 1'b0;
      end
    end
    trig_in = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "glitch_en", int'(glitch_en), 0);
    chk("R1", "busy", int'(busy), 0);
    chk("R1", "done", int'(done), 0);
    // R1 and R8: the count after reset is 0, so a trigger is ignored
    wr_entry(0, 1, 1);
    m_cnt = 0;
    run("R1 R8", 1'b0, 1'b0);

    // R3 R4 R6: sweep of all single-entry pairs
    wr_count(1);
    for (int o = 0; o < 8; o++)
      for (int r = 0; r < 8; r++) begin
        wr_entry(0, o, r);
        run("R3 R4 R6", 1'b0, 1'b0);
      end

    // R5 R7: four chained entries, including zero delays and zero lengths
    wr_entry(0, 0, 1);
    wr_entry(1, 3, 0);
    wr_entry(2, 0, 2);
    wr_entry(3, 5, 7);
    wr_count(4);
    run("R5 R7", 1'b0, 1'b0);

    // R7: a count above MAX_ENTRIES is stored as MAX_ENTRIES
    wr_count(7);
    run("R7 clamp", 1'b0, 1'b0);

    // R7: a shorter count plays only the leading entries
    wr_count(2);
    run("R7 partial", 1'b0, 1'b0);

    // R2: trigger held high does not restart the sequence
    wr_count(3);
    run("R2 hold", 1'b0, 1'b1);

    // R9 R10: trigger and writes during a run, then replay with an unchanged model
    wr_entry(0, 4, 3);
    run("R9 R10", 1'b1, 1'b0);
    run("R10 replay", 1'b0, 1'b0);

    // R8: a count of zero written explicitly
    wr_count(0);
    run("R8", 1'b0, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 8);
    checks++;
    fails++;
    $display("FAIL watchdog expired got=running exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule